// File: doc/BRIEF.md
# MAC Datapath Reset Sequencer

This controller takes one or both datapaths of a 10G Ethernet MAC (transmit, receive) through a safe reset. It drives the MAC's register bank through a simple master port with address, write, read, write data, read data and a wait signal. A command is held on that port until a cycle in which wait is low.

On a request, the sequencer first turns off each chosen datapath. It then polls that direction's status register until no transfer is in flight. If the path stays busy for too long, it gives up waiting and moves on. Next it pulls the direction's active-low reset output, but only while that direction's clock is reported stable, and keeps it low for a minimum number of cycles. After release it waits a settling time of at least 500 ns, counted in clock cycles. Finally it clears the statistics counters and turns the datapath back on.

The `busy` output covers the whole sequence. A one-cycle `done` pulse ends it, and `idle_timeout` then tells whether any idle poll ran out of time. When both directions are requested, each register step is done for transmit and then for receive, and the two reset outputs move together.

Top module: `mac_rst_seq`

## Requirements
- R1: A request (`req_tx` and/or `req_rx` high in a cycle while `busy` is low) sets `busy` high in the following cycle. The first bus operation is then a write of value 1 (bit 0 = disable) to the control register of the first chosen direction. The transmit control register is at 8'h10 and the receive control register at 8'h20, and transmit goes first when both are chosen.
- R2: For each chosen direction, the sequencer reads that direction's status register (transmit 8'h11, receive 8'h21) repeatedly. It stops after the first completed read whose bit 8 (transfer in progress) is 0.
- R3: Polling for a direction also ends when a read completes with bit 8 still 1 after at least IDLE_TO cycles of polling that direction. In that case `idle_timeout` is 1 after `done`. If no poll timed out, it is 0.
- R4: A reset output falls only while the matching clock-stable input is high. While that input is low, the sequencer waits with the reset output high and `busy` high.
- R5: Each reset output stays low for at least HOLD_CYC cycles (never fewer than 3). It is released only while the clock-stable inputs of all chosen directions are high.
- R6: From reset release, at least ceil(SETTLE_NS × CLK_MHZ / 1000) cycles pass before the next bus command (50 cycles at the defaults).
- R7: After settling, the sequencer writes value 1 to the statistics-clear register of each chosen direction (transmit 8'h12, receive 8'h22). Only after all of these does it write value 0 to each chosen control register, and the last bus operation is that re-enable write.
- R8: `busy` stays high from the request until the final re-enable write completes. `done` is a single-cycle pulse while `busy` is low. At reset, `busy` and `done` are 0, both reset outputs are 1, and the bus is idle.
- R9: Requests that arrive while `busy` is high are ignored: they cause no bus operation and no second `done`.
- R10: A bus command (address, write, read, write data) is held unchanged while `bus_wait` is high, and read and write are never high together.
- R11: When both directions are requested, the two reset outputs fall and rise in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| req_tx | input | 1 | Request a transmit datapath reset |
| req_rx | input | 1 | Request a receive datapath reset |
| tx_clk_ok | input | 1 | Transmit clock reported stable |
| rx_clk_ok | input | 1 | Receive clock reported stable |
| bus_addr | output | AW | Register address |
| bus_wr | output | 1 | Write command |
| bus_rd | output | 1 | Read command |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid in the cycle a read completes |
| bus_wait | input | 1 | Command not yet accepted; hold it |
| tx_rst_n | output | 1 | Active-low transmit datapath reset |
| rx_rst_n | output | 1 | Active-low receive datapath reset |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |
| idle_timeout | output | 1 | An idle poll ended on timeout |

## Verification
A sequencer stuck in a wrong state shows up at the ports as a bus transaction that is out of order, repeated or missing. The bench notices this as soon as the offending command completes. A hold or settle counter that is off by some cycles changes the measured reset-low width or the measured gap before the statistics-clear write. Both are measured in cycles, so the error is visible within that one sequence. A wrong direction pointer shows up as traffic to the other direction's addresses, or as a final write that is not the re-enable of the last chosen path.

// File: rtl/mac_rst_seq.sv
module mac_rst_seq #(
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int CLK_MHZ   = 100,
  parameter int SETTLE_NS = 500,
  parameter int HOLD_CYC  = 3,
  parameter int IDLE_TO   = 1000,
  parameter logic [AW-1:0] TX_CTL = 8'h10,
  parameter logic [AW-1:0] TX_STS = 8'h11,
  parameter logic [AW-1:0] TX_CLR = 8'h12,
  parameter logic [AW-1:0] RX_CTL = 8'h20,
  parameter logic [AW-1:0] RX_STS = 8'h21,
  parameter logic [AW-1:0] RX_CLR = 8'h22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_tx,
  input  logic          req_rx,
  input  logic          tx_clk_ok,
  input  logic          rx_clk_ok,
  output logic [AW-1:0] bus_addr,
  output logic          bus_wr,
  output logic          bus_rd,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_wait,
  output logic          tx_rst_n,
  output logic          rx_rst_n,
  output logic          busy,
  output logic          done,
  output logic          idle_timeout
);
  localparam int HOLD_EFF   = (HOLD_CYC < 3) ? 3 : HOLD_CYC;
  localparam int SETTLE_CYC = (SETTLE_NS * CLK_MHZ + 999) / 1000;
  localparam int CMAX0      = (IDLE_TO > SETTLE_CYC) ? IDLE_TO : SETTLE_CYC;
  localparam int CMAX       = (CMAX0 > HOLD_EFF) ? CMAX0 : HOLD_EFF;
  localparam int CW         = $clog2(CMAX + 2);

  typedef enum logic [2:0] {S_IDLE, S_DIS, S_POLL, S_CLKW, S_HOLD, S_SETTLE, S_CLR, S_EN} st_t;

  st_t           st;
  logic [1:0]    sel;
  logic          cur, first, more, ack, clk_good;
  logic [CW-1:0] cnt;

  assign first    = ~sel[0];
  assign more     = ~cur & sel[1];
  assign ack      = (bus_wr | bus_rd) & ~bus_wait;
  assign clk_good = (tx_clk_ok | ~sel[0]) & (rx_clk_ok | ~sel[1]);
  assign busy     = (st != S_IDLE);
  assign bus_wr   = (st == S_DIS) | (st == S_CLR) | (st == S_EN);
  assign bus_rd   = (st == S_POLL);
  assign bus_wdata = DW'((st == S_DIS) | (st == S_CLR));

  always_comb begin
    case (st)
      S_DIS, S_EN: bus_addr = cur ? RX_CTL : TX_CTL;
      S_POLL:      bus_addr = cur ? RX_STS : TX_STS;
      S_CLR:       bus_addr = cur ? RX_CLR : TX_CLR;
      default:     bus_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sel <= 2'b00; cur <= 1'b0; cnt <= '0;
      idle_timeout <= 1'b0; done <= 1'b0; tx_rst_n <= 1'b1; rx_rst_n <= 1'b1;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_tx | req_rx) begin
          sel <= {req_rx, req_tx}; cur <= ~req_tx; idle_timeout <= 1'b0; st <= S_DIS;
        end
        S_DIS: if (ack) begin
          cnt <= '0;
          if (more) cur <= 1'b1;
          else begin cur <= first; st <= S_POLL; end
        end
        S_POLL: begin
          if (cnt != '1) cnt <= cnt + CW'(1);
          if (ack && (!bus_rdata[8] || cnt >= CW'(IDLE_TO))) begin
            if (bus_rdata[8]) idle_timeout <= 1'b1;
            cnt <= '0;
            if (more) cur <= 1'b1;
            else st <= S_CLKW;
          end
        end
        S_CLKW: if (clk_good) begin
          tx_rst_n <= ~sel[0]; rx_rst_n <= ~sel[1]; cnt <= '0; st <= S_HOLD;
        end
        S_HOLD:
          if (cnt < CW'(HOLD_EFF - 1)) cnt <= cnt + CW'(1);
          else if (clk_good) begin
            tx_rst_n <= 1'b1; rx_rst_n <= 1'b1; cnt <= '0; st <= S_SETTLE;
          end
        S_SETTLE:
          if (cnt >= CW'(SETTLE_CYC - 1)) begin cur <= first; st <= S_CLR; end
          else cnt <= cnt + CW'(1);
        S_CLR: if (ack) begin
          if (more) cur <= 1'b1;
          else begin cur <= first; st <= S_EN; end
        end
        S_EN: if (ack) begin
          if (more) cur <= 1'b1;
          else begin st <= S_IDLE; done <= 1'b1; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [7:0] low_cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cyc <= '0;
    else if (tx_rst_n & rx_rst_n) low_cyc <= '0;
    else if (low_cyc != 8'hff) low_cyc <= low_cyc + 8'd1;
  end

  // R4
  tx_fall_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_rst_n) |-> $past(tx_clk_ok));
  // R4
  rx_fall_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_rst_n) |-> $past(rx_clk_ok));
  // R5
  hold_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_rst_n) || $rose(rx_rst_n)) |-> (low_cyc >= 8'(HOLD_EFF)));
  // R10
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));
  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && bus_wait) |=>
      ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_wr) && $stable(bus_rd)));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  idle_rst_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tx_rst_n && rx_rst_n));
endmodule

// File: tb/mac_rst_seq_tb_top.sv
module mac_rst_seq_tb_top;
  localparam int AW = 8, DW = 32, IDLE_TO = 40, HOLD = 3, SETTLE = 50;
  localparam logic [7:0] TX_CTL = 8'h10, TX_STS = 8'h11, TX_CLR = 8'h12;
  localparam logic [7:0] RX_CTL = 8'h20, RX_STS = 8'h21, RX_CLR = 8'h22;

  // fields: tx, rx, wait states[3:0], tx busy polls[7:0], rx busy polls[7:0], expected timeout
  localparam int NV = 6;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'd0, 8'd0,   8'd0,   1'b0},
    {1'b1, 1'b0, 4'd2, 8'd3,   8'd0,   1'b0},
    {1'b0, 1'b1, 4'd1, 8'd0,   8'd5,   1'b0},
    {1'b1, 1'b1, 4'd0, 8'd2,   8'd4,   1'b0},
    {1'b1, 1'b0, 4'd0, 8'd255, 8'd0,   1'b1},
    {1'b1, 1'b1, 4'd3, 8'd1,   8'd255, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_tx = 1'b0, req_rx = 1'b0, tx_clk_ok = 1'b1, rx_clk_ok = 1'b1;
  logic [AW-1:0] bus_addr;
  logic bus_wr, bus_rd, bus_wait, tx_rst_n, rx_rst_n, busy, done, idle_timeout;
  logic [DW-1:0] bus_wdata, bus_rdata;

  always #5 clk = ~clk;

  mac_rst_seq #(.IDLE_TO(IDLE_TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_tx(req_tx), .req_rx(req_rx),
    .tx_clk_ok(tx_clk_ok), .rx_clk_ok(rx_clk_ok),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_wait(bus_wait),
    .tx_rst_n(tx_rst_n), .rx_rst_n(rx_rst_n), .busy(busy), .done(done),
    .idle_timeout(idle_timeout));

  // register-bank model
  int wst = 0, wcnt = 0, tx_left = 0, rx_left = 0;
  assign bus_wait  = (bus_wr | bus_rd) && (wcnt < wst);
  assign bus_rdata = ((bus_addr == TX_STS && tx_left > 0) || (bus_addr == RX_STS && rx_left > 0))
                     ? 32'h100 : 32'h0;
  always @(posedge clk) begin
    if ((bus_wr | bus_rd) && bus_wait) wcnt <= wcnt + 1; else wcnt <= 0;
    if (bus_rd && !bus_wait && bus_addr == TX_STS && tx_left > 0) tx_left <= tx_left - 1;
    if (bus_rd && !bus_wait && bus_addr == RX_STS && rx_left > 0) rx_left <= rx_left - 1;
  end

  // port monitor
  int ntx, txr, rxr, clrs, order_v, rx_txn, stab_v, both_v, done_cnt, dbusy_v;
  int lowcnt, lowmax, gapc, gapm, split_v, clk_v, ndirs;
  bit gap_on, pcw, ptx, ptxok, prxok, prx;
  logic [7:0] fa, la; logic fw, lw; logic [31:0] fd, ld, pwd; logic [7:0] paddr; logic pwr, prd;

  task automatic clr_mon();
    ntx = 0; txr = 0; rxr = 0; clrs = 0; order_v = 0; rx_txn = 0; done_cnt = 0;
    dbusy_v = 0; lowcnt = 0; lowmax = 0; gapc = 0; gapm = -1; gap_on = 0; split_v = 0;
    fa = 0; la = 0; fw = 0; lw = 0; fd = 0; ld = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_wr && bus_rd) both_v++;
      if (pcw && (bus_addr != paddr || bus_wr != pwr || bus_rd != prd || bus_wdata != pwd)) stab_v++;
      if (gap_on && (bus_wr || bus_rd)) begin gapm = gapc; gap_on = 0; end
      else if (gap_on) gapc++;
      if ((bus_wr || bus_rd) && !bus_wait) begin
        ntx++;
        if (ntx == 1) begin fa = bus_addr; fw = bus_wr; fd = bus_wdata; end
        la = bus_addr; lw = bus_wr; ld = bus_wdata;
        if (bus_rd && bus_addr == TX_STS) txr++;
        if (bus_rd && bus_addr == RX_STS) rxr++;
        if (bus_wr && (bus_addr == TX_CLR || bus_addr == RX_CLR)) clrs++;
        if (bus_wr && (bus_addr == TX_CTL || bus_addr == RX_CTL) && bus_wdata == 0 && clrs < ndirs) order_v++;
        if (bus_addr >= 8'h20) rx_txn++;
      end
      if (done) begin done_cnt++; if (busy) dbusy_v++; end
      if (ptx && !tx_rst_n && !ptxok) clk_v++;
      if (prx && !rx_rst_n && !prxok) clk_v++;
      if (ndirs == 2 && tx_rst_n != rx_rst_n) split_v++;
      if (!tx_rst_n || !rx_rst_n) lowcnt++;
      else if (lowcnt > 0) begin
        if (lowcnt > lowmax) lowmax = lowcnt;
        lowcnt = 0; gap_on = 1; gapc = 1;
      end
    end
    pcw = (bus_wr || bus_rd) && bus_wait;
    paddr = bus_addr; pwr = bus_wr; prd = bus_rd; pwd = bus_wdata;
    ptx = tx_rst_n; prx = rx_rst_n; ptxok = tx_clk_ok; prxok = rx_clk_ok;
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(input bit t, input bit r);
    @(posedge clk); clr_mon();
    ndirs = int'(t) + int'(r);
    @(negedge clk); req_tx = t; req_rx = r;
    @(negedge clk); req_tx = 0; req_rx = 0;
    chk(busy == 1'b1, "R1 busy after request", int'(busy), 1);
  endtask

  task automatic wait_done();
    int n = 0;
    while (done_cnt == 0 && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) chk(0, "watchdog", n, 5000);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    clr_mon(); stab_v = 0; both_v = 0; clk_v = 0; ndirs = 0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(busy == 0 && done == 0, "R8 idle outputs at reset", int'(busy), 0);
    chk(tx_rst_n && rx_rst_n && !bus_wr && !bus_rd, "R8 reset outputs high, bus idle", int'(tx_rst_n), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic t, r, et; int w, tp, rp, exp_n;
      {t, r} = VEC[i][22:21]; w = int'(VEC[i][20:17]);
      tp = int'(VEC[i][16:9]); rp = int'(VEC[i][8:1]); et = VEC[i][0];
      wst = w; tx_left = tp; rx_left = rp;
      start(t, r);
      wait_done();
      chk(fa == (t ? TX_CTL : RX_CTL) && fw && fd == 1, "R1 first op disables first direction", int'(fa), int'(t ? TX_CTL : RX_CTL));
      if (t && tp != 255) chk(txr == tp + 1, "R2 tx status reads", txr, tp + 1);
      if (r && rp != 255) chk(rxr == rp + 1, "R2 rx status reads", rxr, rp + 1);
      chk(idle_timeout == et, "R3 timeout flag", int'(idle_timeout), int'(et));
      chk(lowmax >= HOLD, "R5 reset low width", lowmax, HOLD);
      chk(gapm >= SETTLE, "R6 settle gap", gapm, SETTLE);
      chk(clrs == ndirs && order_v == 0, "R7 stats clear before re-enable", clrs, ndirs);
      chk(la == (r ? RX_CTL : TX_CTL) && lw && ld == 0, "R7 last op re-enables", int'(la), int'(r ? RX_CTL : TX_CTL));
      chk(done_cnt == 1 && dbusy_v == 0 && !busy, "R8 single done, busy low", done_cnt, 1);
      if (!t) chk(ntx == rx_txn, "R1 no tx traffic on rx-only", ntx - rx_txn, 0);
      if (t && r) chk(split_v == 0, "R11 resets move together", split_v, 0);
      exp_n = 0;
      if (t && tp != 255) exp_n += tp + 4;
      if (r && rp != 255) exp_n += rp + 4;
      if (tp != 255 && rp != 255) chk(ntx == exp_n, "R7 transaction count", ntx, exp_n);
    end

    // R4: clock not stable delays reset
    tx_clk_ok = 0; wst = 0; tx_left = 0; rx_left = 0;
    start(1, 0);
    repeat (100) @(negedge clk);
    chk(tx_rst_n == 1 && busy == 1, "R4 reset held off while clock unstable", int'(tx_rst_n), 1);
    tx_clk_ok = 1;
    wait_done();
    chk(done_cnt == 1 && lowmax >= HOLD, "R4 sequence completes after clock stable", done_cnt, 1);

    // R9: request during busy ignored
    wst = 2; tx_left = 10;
    start(1, 0);
    repeat (7) @(negedge clk);
    req_rx = 1; req_tx = 1; @(negedge clk); req_rx = 0; req_tx = 0;
    wait_done();
    chk(rx_txn == 0, "R9 no rx traffic from ignored request", rx_txn, 0);
    repeat (20) @(negedge clk);
    chk(done_cnt == 1 && !busy, "R9 no second sequence", done_cnt, 1);

    chk(stab_v == 0, "R10 command stable under wait", stab_v, 0);
    chk(both_v == 0, "R10 read and write exclusive", both_v, 0);
    chk(clk_v == 0, "R4 no reset fall with clock unstable", clk_v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule